// File: doc/BRIEF.md
# Leaky Per-DIMM Error Counters with Sparing Request

This block tracks how often memory errors hit each DIMM, or each DIMM pair when the memory runs in dual-channel mode. Every slot holds two counters: one for corrected errors and one for uncorrectable errors. A shared interval timer removes one count from every nonzero counter at a programmable period. Because of this leak, a counter shows the recent error rate and not a lifetime total.

Each counter is compared against its own programmable threshold. When either counter of a slot reaches its threshold, the slot raises a sparing request. That request stays set until software clears it. It is meant to start the copy of the failing DIMM onto a spare, and that copy engine sits outside this block.

Error reports arrive as a one-cycle strobe. The strobe carries a DIMM index and a flag that says whether the error was uncorrectable.

Top module: `dimm_err_leak_top`

## Requirements
- R1: After reset, every correctable count, every uncorrectable count and every sparing request is 0.
- R2: An error strobe with `err_uncorr`=0 adds one to the correctable count of the selected slot. With `err_uncorr`=1 it adds one to the uncorrectable count. The change is visible on the clock edge that samples the strobe, and no other counter changes.
- R3: With `dual_mode`=0 the selected slot is `err_dimm`. With `dual_mode`=1 it is `err_dimm` shifted right by one, so slots in the upper half never count.
- R4: A counter at its maximum of 2^CNT_W-1 stays there when more errors arrive.
- R5: When `decay_period`=P>0, every nonzero counter drops by one on the P-th rising edge after the period was written, and again every P edges after that. A counter at 0 stays at 0.
- R6: If an increment and a decay hit the same nonzero counter on the same edge, its value does not change. A counter at 0 that takes an error on a decay edge becomes 1.
- R7: When `decay_period`=0, no counter ever decays.
- R8: `spare_req[k]` rises on the same edge on which slot k's correctable count becomes at least `ce_thresh`, or its uncorrectable count becomes at least `ue_thresh`. A threshold of 0 turns that comparison off.
- R9: A sparing request stays set after the count falls back. `spare_clr[k]`=1 clears it on the next edge, unless the threshold condition still holds, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error report strobe, one cycle per error |
| err_dimm | input | $clog2(NUM_DIMMS) | DIMM index of the reported error |
| err_uncorr | input | 1 | 1 = uncorrectable error, 0 = corrected error |
| dual_mode | input | 1 | 1 = counters are kept per DIMM pair |
| ce_thresh | input | CNT_W | Threshold for the correctable count, 0 = off |
| ue_thresh | input | CNT_W | Threshold for the uncorrectable count, 0 = off |
| decay_period | input | PERIOD_W | Cycles between decay steps, 0 = no decay |
| spare_clr | input | NUM_DIMMS | Per-slot clear of the sparing request |
| ce_count | output | NUM_DIMMS*CNT_W | Correctable counts, slot k in bits k*CNT_W upward |
| ue_count | output | NUM_DIMMS*CNT_W | Uncorrectable counts, same packing |
| spare_req | output | NUM_DIMMS | Sticky sparing request per slot |

## Verification
With decay off, the bench visits every DIMM index and both error kinds, in single-channel and then in dual-channel mode. It sends 17 errors to each target. This separates slot decoding from type decoding and also walks every counter up into saturation. After each strobe, every slot's counts and requests are compared with an arithmetic model, so a request that fires one error early or late shows up. A timed run with a small period places error strobes exactly on decay edges and next to them. This separates a plain decrement, the cancel case and the at-zero case. Threshold changes and clear pulses are applied once a request has latched, to test stickiness and which of set and clear wins.

// File: rtl/dimm_err_pkg.sv
package dimm_err_pkg;

    typedef enum logic {
        ERR_CORR   = 1'b0,
        ERR_UNCORR = 1'b1
    } err_kind_e;

endpackage

// File: rtl/dimm_decay_timer.sv
module dimm_decay_timer #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (period != '0) && (tmr_q.cnt >= period - 1'b1);
        if (period == '0 || tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > 1) ##1 $stable(period) |-> !tick);

endmodule

// File: rtl/dimm_err_slot.sv
module dimm_err_slot #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_ce,
    input  logic             inc_ue,
    input  logic             tick,
    input  logic [CNT_W-1:0] thr_ce,
    input  logic [CNT_W-1:0] thr_ue,
    input  logic             clr,
    output logic [CNT_W-1:0] ce_cnt,
    output logic [CNT_W-1:0] ue_cnt,
    output logic             req
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] ce;
        logic [CNT_W-1:0] ue;
        logic             req;
    } slot_state_t;

    slot_state_t slot_d, slot_q;
    logic        hit;

    function automatic logic [CNT_W-1:0] next_count(
        input logic [CNT_W-1:0] cur,
        input logic             inc,
        input logic             dec
    );
        logic leak;
        leak = dec && (cur != '0);
        if (inc && leak) begin
            next_count = cur;
        end else if (inc) begin
            next_count = (cur == CNT_MAX) ? cur : cur + 1'b1;
        end else if (leak) begin
            next_count = cur - 1'b1;
        end else begin
            next_count = cur;
        end
    endfunction

    always_comb begin
        slot_d    = slot_q;
        slot_d.ce = next_count(slot_q.ce, inc_ce, tick);
        slot_d.ue = next_count(slot_q.ue, inc_ue, tick);
        hit       = ((thr_ce != '0) && (slot_d.ce >= thr_ce)) ||
                    ((thr_ue != '0) && (slot_d.ue >= thr_ue));
        slot_d.req = hit || (slot_q.req && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ce_cnt = slot_q.ce;
    assign ue_cnt = slot_q.ue;
    assign req    = slot_q.req;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.ce == CNT_MAX && inc_ce && !tick) |=> (slot_q.ce == CNT_MAX));

    // R4
    ue_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.ue == CNT_MAX && inc_ue && !tick) |=> (slot_q.ue == CNT_MAX));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.ce == '0 && !inc_ce) |=> (slot_q.ce == '0));

    // R6
    inc_decay_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ce && tick && slot_q.ce != '0) |=> $stable(slot_q.ce));

    // R8
    req_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(thr_ce) && thr_ce != '0 && slot_q.ce >= thr_ce) |-> slot_q.req);

    // R9
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.req && !clr) |=> slot_q.req);

endmodule

// File: rtl/dimm_err_leak_top.sv
module dimm_err_leak_top
    import dimm_err_pkg::*;
#(
    parameter int NUM_DIMMS = 4,
    parameter int CNT_W     = 4,
    parameter int PERIOD_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       err_valid,
    input  logic [$clog2(NUM_DIMMS)-1:0] err_dimm,
    input  logic                       err_uncorr,
    input  logic                       dual_mode,
    input  logic [CNT_W-1:0]           ce_thresh,
    input  logic [CNT_W-1:0]           ue_thresh,
    input  logic [PERIOD_W-1:0]        decay_period,
    input  logic [NUM_DIMMS-1:0]       spare_clr,
    output logic [NUM_DIMMS*CNT_W-1:0] ce_count,
    output logic [NUM_DIMMS*CNT_W-1:0] ue_count,
    output logic [NUM_DIMMS-1:0]       spare_req
);

    localparam int IDX_W = $clog2(NUM_DIMMS);
    localparam int HALF  = NUM_DIMMS / 2;

    logic [IDX_W-1:0]     slot_sel;
    err_kind_e            kind;
    logic [NUM_DIMMS-1:0] inc_ce;
    logic [NUM_DIMMS-1:0] inc_ue;
    logic                 tick;

    always_comb begin
        kind     = err_kind_e'(err_uncorr);
        slot_sel = dual_mode ? (err_dimm >> 1) : err_dimm;
        for (int k = 0; k < NUM_DIMMS; k++) begin
            inc_ce[k] = err_valid && (slot_sel == IDX_W'(k)) && (kind == ERR_CORR);
            inc_ue[k] = err_valid && (slot_sel == IDX_W'(k)) && (kind == ERR_UNCORR);
        end
    end

    dimm_decay_timer #(
        .PERIOD_W (PERIOD_W)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (decay_period),
        .tick   (tick)
    );

    for (genvar g = 0; g < NUM_DIMMS; g++) begin : g_slot
        dimm_err_slot #(
            .CNT_W (CNT_W)
        ) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_ce (inc_ce[g]),
            .inc_ue (inc_ue[g]),
            .tick   (tick),
            .thr_ce (ce_thresh),
            .thr_ue (ue_thresh),
            .clr    (spare_clr[g]),
            .ce_cnt (ce_count[g*CNT_W +: CNT_W]),
            .ue_cnt (ue_count[g*CNT_W +: CNT_W]),
            .req    (spare_req[g])
        );
    end

    // R2
    inc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_ce, inc_ue}));

    // R3
    dual_upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode |-> (((inc_ce | inc_ue) >> HALF) == '0));

endmodule

// File: tb/dimm_err_leak_top_tb_top.sv
module dimm_err_leak_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int CW   = 4;
    localparam int PW   = 8;
    localparam int MAXC = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_valid = 1'b0;
    logic [1:0]    err_dimm = '0;
    logic          err_uncorr = 1'b0;
    logic          dual_mode = 1'b0;
    logic [CW-1:0] ce_thresh = '0;
    logic [CW-1:0] ue_thresh = '0;
    logic [PW-1:0] decay_period = '0;
    logic [N-1:0]  spare_clr = '0;
    logic [N*CW-1:0] ce_count;
    logic [N*CW-1:0] ue_count;
    logic [N-1:0]  spare_req;

    int total = 0;
    int bad   = 0;
    int ce_m[N];
    int ue_m[N];
    bit req_m[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    dimm_err_leak_top #(.NUM_DIMMS(N), .CNT_W(CW), .PERIOD_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_dimm(err_dimm),
        .err_uncorr(err_uncorr), .dual_mode(dual_mode), .ce_thresh(ce_thresh),
        .ue_thresh(ue_thresh), .decay_period(decay_period), .spare_clr(spare_clr),
        .ce_count(ce_count), .ue_count(ue_count), .spare_req(spare_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < N; s++) begin
            chk($sformatf("%s ce slot%0d", tag, s), int'(ce_count[s*CW +: CW]), ce_m[s]);
            chk($sformatf("%s ue slot%0d", tag, s), int'(ue_count[s*CW +: CW]), ue_m[s]);
            chk($sformatf("%s req slot%0d", tag, s), int'(spare_req[s]), int'(req_m[s]));
        end
    endtask

    task automatic model_req(input bit [N-1:0] clr);
        for (int s = 0; s < N; s++) begin
            req_m[s] = ((ce_thresh != 0) && (ce_m[s] >= int'(ce_thresh))) ||
                       ((ue_thresh != 0) && (ue_m[s] >= int'(ue_thresh))) ||
                       (req_m[s] && !clr[s]);
        end
    endtask

    task automatic step(input bit [N-1:0] clr);
        spare_clr = clr;
        @(posedge clk);
        @(negedge clk);
        spare_clr = '0;
        model_req(clr);
    endtask

    task automatic inject(input int d, input bit u);
        int s;
        err_dimm   = 2'(d);
        err_uncorr = u;
        err_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        err_valid = 1'b0;
        s = dual_mode ? (d >> 1) : d;
        if (u) ue_m[s] = (ue_m[s] < MAXC) ? ue_m[s] + 1 : MAXC;
        else   ce_m[s] = (ce_m[s] < MAXC) ? ce_m[s] + 1 : MAXC;
        model_req('0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < N; s++) begin
            ce_m[s] = 0; ue_m[s] = 0; req_m[s] = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check_all("R1");

        // R2 R3 R4 R8 single-channel sweep, decay off
        ce_thresh = 4'd6;
        ue_thresh = 4'd3;
        for (int d = 0; d < N; d++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 17; k++) begin
                    inject(d, bit'(u));
                    check_all((k >= 14) ? "R4" : ((u == 1 && k == 2) || (u == 0 && k == 5)) ? "R8" : "R2");
                end
            end
        end

        // R8 thresholds off, R9 partial clear
        ce_thresh = '0;
        ue_thresh = '0;
        step(4'b0101);
        check_all("R9 clear");
        repeat (3) step('0);
        check_all("R9 sticky");
        // R8 raising a threshold re-asserts on the next edge
        ce_thresh = 4'd15;
        step('0);
        check_all("R8 rearm");
        // R9 set wins over clear while condition holds
        step(4'b1111);
        check_all("R9 set wins");

        // R3 dual-channel mode
        ce_thresh = '0;
        ue_thresh = '0;
        do_reset();
        dual_mode = 1'b1;
        for (int d = 0; d < N; d++) begin
            inject(d, 1'b0);
            check_all("R3 ce");
            inject(d, 1'b1);
            check_all("R3 ue");
        end

        // R5 R6 R7 decay
        dual_mode = 1'b0;
        do_reset();
        inject(0, 1'b0); inject(0, 1'b0); inject(0, 1'b0);
        inject(1, 1'b1);
        repeat (50) @(negedge clk);
        check_all("R7");
        decay_period = 8'd5;
        repeat (4) @(negedge clk);
        check_all("R5 before");
        @(negedge clk);
        ce_m[0] = 2; ue_m[1] = 0;
        check_all("R5 first");
        repeat (4) @(negedge clk);
        inject(0, 1'b0);
        ce_m[0] = 2;
        check_all("R6 cancel");
        repeat (4) @(negedge clk);
        inject(2, 1'b0);
        ce_m[0] = 1; ce_m[2] = 1;
        check_all("R6 zero");
        repeat (5) @(negedge clk);
        ce_m[0] = 0; ce_m[2] = 0;
        check_all("R5 floor");
        repeat (5) @(negedge clk);
        check_all("R5 stays zero");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule